// File: doc/BRIEF.md
# Asynchronous Serial Channel with Pointer-Addressed Registers

This block is one asynchronous channel of a serial controller. A processor talks to it through a byte-wide control port and a data port. Configuration registers are not decoded from an address bus. The first control write loads a small register pointer. The next control write goes to the register that pointer names, and the pointer then falls back to zero.

The transmit path has a one-byte holding buffer that feeds a frame shift register. It builds start, data, parity and stop bits from the selected character length and line mode. The transmit line follows a fixed priority: a disabled transmitter idles at mark, an enabled transmitter with break set drives space, and otherwise the frame bits go out. The receive path synchronises the incoming line and finds a start edge. It then samples each bit near its centre at the selected clock multiple. The channel reports a buffer-empty flag, an all-sent flag and a receive-available flag. A single-cycle `tick` input supplies the base bit-clock enable.

Top module: `sch_async_chan`

## Requirements
- R1: When the pointer is zero, a control write loads the pointer from wdata bits 2:0. When the pointer is nonzero, a control write goes to register 3 (receive control), 4 (line mode) or 5 (transmit control) and the pointer returns to zero, so the next control write is a command again.
- R2: In the receive-control register, bits 7:6 set the received character length (00=5, 01=6, 10=7, 11=8 bits) and bit 0 enables the receiver, so 0xC1 means 8-bit characters with the receiver enabled.
- R3: In the line-mode register, bits 7:6 set the bit time in ticks (00=1, 01=16, 10=32, 11=64). Bit 3 set selects two stop bits (01 in bits 3:2 gives one). Bit 0 enables parity and bit 1 selects even parity (0 = odd). 0x44 therefore means x16, one stop bit, no parity.
- R4: In the transmit-control register, bits 6:5 set the transmit character length (same coding as R2), bit 4 is send-break and bit 3 enables the transmitter, so 0x68 means 8-bit characters with the transmitter enabled. A frame is a 0 start bit, data LSB first, the optional parity bit, then stop bits at 1.
- R5: While the transmitter is disabled, txd stays at 1 regardless of break or buffered data.
- R6: While the transmitter is enabled and send-break is set, txd is 0, and the holding buffer is not loaded into the shifter.
- R7: When the shifter is idle or finishes a character, and the transmitter is enabled, break is clear and the holding buffer is full, the byte moves into the shifter and stat_txe goes to 1. A byte written while another is shifting waits with stat_txe at 0.
- R8: stat_all_sent goes to 1 when a character finishes with the holding buffer empty.
- R9: The receiver accepts line bits only while its enable bit is 1. A character sent while it is disabled leaves stat_rx_avail and rx_data unchanged.
- R10: A received character is sampled at mid-bit from the start edge, sets stat_rx_avail and appears on rx_data. A dat_rd pulse clears stat_rx_avail.
- R11: A dat_wr clears stat_txe and stat_all_sent on the next clock. Reset gives txd=1, stat_txe=1, stat_all_sent=1, stat_rx_avail=0, both directions disabled and a zero pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base bit-clock enable, one cycle wide |
| ctl_wr | input | 1 | Control-port write strobe |
| dat_wr | input | 1 | Data-port write strobe (fills holding buffer) |
| dat_rd | input | 1 | Data-port read strobe (clears receive-available) |
| wdata | input | 8 | Write data for both ports |
| rx_data | output | 8 | Last received character, right-aligned |
| stat_txe | output | 1 | Transmit holding buffer empty |
| stat_all_sent | output | 1 | All characters sent |
| stat_rx_avail | output | 1 | Received character available |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The bench builds the block with the package defaults: an 8-bit data path, a 6-bit divide counter that reaches the x64 rate, and a 12-bit frame that holds 8 data bits with parity and two stop bits. With `tick` held high every cycle, the x16 and x32 bit times are 16 and 32 clocks. Whole frames in several lengths, parity senses and rates therefore fit in a short run. They are decoded from txd by a scoreboard monitor and compared in write order.

// File: rtl/sch_pkg.sv
package sch_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = 12;
    localparam int DIV_W   = 6;
    localparam int PTR_W   = 3;

    typedef struct packed {
        logic [1:0] clk_rate;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic [1:0] bpc;
        logic       brk;
        logic       en;
    } txcfg_t;

    typedef struct packed {
        logic [1:0] clk_rate;
        logic       par_en;
        logic [1:0] bpc;
        logic       en;
    } rxcfg_t;

    function automatic logic [3:0] bpc_len(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic [DIV_W-1:0] div_last(input logic [1:0] rate);
        case (rate)
            2'b00:   return DIV_W'(0);
            2'b01:   return DIV_W'(15);
            2'b10:   return DIV_W'(31);
            default: return DIV_W'(63);
        endcase
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                       input txcfg_t c);
        logic [FRAME_W-1:0] f;
        logic [3:0]         n;
        logic               p;
        f    = '1;
        f[0] = 1'b0;
        n    = bpc_len(c.bpc);
        p    = ~c.par_even;
        for (int i = 0; i < DATA_W; i++) begin
            if (4'(i) < n) begin
                f[i+1] = d[i];
                p      = p ^ d[i];
            end
        end
        if (c.par_en) f[n + 4'd1] = p;
        return f;
    endfunction

    function automatic logic [3:0] frame_len(input txcfg_t c);
        return 4'd1 + bpc_len(c.bpc) + {3'b000, c.par_en} + (c.two_stop ? 4'd2 : 4'd1);
    endfunction

endpackage

// File: rtl/sch_regs.sv
module sch_regs
    import sch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    output txcfg_t            txc,
    output rxcfg_t            rxc
);
    logic [PTR_W-1:0] ptr;
    logic [1:0]       rate;
    logic             two_stop, par_en, par_even;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            rate     <= 2'b00;
            two_stop <= 1'b0;
            par_en   <= 1'b0;
            par_even <= 1'b0;
            txc.bpc  <= 2'b00;
            txc.brk  <= 1'b0;
            txc.en   <= 1'b0;
            rxc.bpc  <= 2'b00;
            rxc.en   <= 1'b0;
        end else if (ctl_wr) begin
            if (ptr == '0) begin
                ptr <= wdata[PTR_W-1:0];
            end else begin
                ptr <= '0;
                case (ptr)
                    3'd3: begin
                        rxc.bpc <= wdata[7:6];
                        rxc.en  <= wdata[0];
                    end
                    3'd4: begin
                        rate     <= wdata[7:6];
                        two_stop <= wdata[3];
                        par_even <= wdata[1];
                        par_en   <= wdata[0];
                    end
                    3'd5: begin
                        txc.bpc <= wdata[6:5];
                        txc.brk <= wdata[4];
                        txc.en  <= wdata[3];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign txc.clk_rate = rate;
    assign txc.two_stop = two_stop;
    assign txc.par_en   = par_en;
    assign txc.par_even = par_even;
    assign rxc.clk_rate = rate;
    assign rxc.par_en   = par_en;

    AST_PTR_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ptr != '0) |=> (ptr == '0)); // R1

endmodule

// File: rtl/sch_tx.sv
module sch_tx
    import sch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  txcfg_t            cfg,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              txd,
    output logic              txe,
    output logic              all_sent
);
    logic [DATA_W-1:0]  hold_q;
    logic               full_q;
    logic               busy;
    logic [FRAME_W-1:0] sh;
    logic [3:0]         left;
    logic [DIV_W-1:0]   dcnt;
    logic               bit_end, char_end, load;

    assign bit_end  = busy && tick && (dcnt == div_last(cfg.clk_rate));
    assign char_end = bit_end && (left == 4'd1);
    assign load     = (!busy || char_end) && cfg.en && !cfg.brk && full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            sh       <= '1;
            left     <= '0;
            dcnt     <= '0;
            full_q   <= 1'b0;
            hold_q   <= '0;
            all_sent <= 1'b1;
            txd      <= 1'b1;
        end else begin
            if (load) begin
                sh   <= build_frame(hold_q, cfg);
                left <= frame_len(cfg);
                busy <= 1'b1;
                dcnt <= '0;
            end else if (char_end) begin
                busy <= 1'b0;
                left <= '0;
                dcnt <= '0;
            end else if (bit_end) begin
                sh   <= {1'b1, sh[FRAME_W-1:1]};
                left <= left - 4'd1;
                dcnt <= '0;
            end else if (busy && tick) begin
                dcnt <= dcnt + DIV_W'(1);
            end

            if (dat_wr) begin
                full_q <= 1'b1;
                hold_q <= wdata;
            end else if (load) begin
                full_q <= 1'b0;
            end

            if (dat_wr)                    all_sent <= 1'b0;
            else if (char_end && !full_q)  all_sent <= 1'b1;

            if (!cfg.en)     txd <= 1'b1;
            else if (cfg.brk) txd <= 1'b0;
            else if (busy)   txd <= sh[0];
            else             txd <= 1'b1;
        end
    end

    assign txe = !full_q;

    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg.en) |-> txd); // R5
    AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (rst)
        $past(cfg.en && cfg.brk) |-> !txd); // R6
    AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (load && !dat_wr) |=> txe); // R7
    AST_ALLSENT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        all_sent |-> txe); // R8

endmodule

// File: rtl/sch_rx.sv
module sch_rx
    import sch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  rxcfg_t            cfg,
    input  logic              rxd,
    input  logic              dat_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_avail
);
    logic               s1, s2;
    logic               active;
    logic [3:0]         idx;
    logic [DIV_W-1:0]   dcnt, tgt;
    logic [DATA_W-1:0]  sh;
    logic [3:0]         n, last;
    logic               hit, done;

    assign n    = bpc_len(cfg.bpc);
    assign last = n + {3'b000, cfg.par_en} + 4'd1;
    assign hit  = cfg.en && active && tick && (dcnt == tgt);
    assign done = hit && (idx == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1       <= 1'b1;
            s2       <= 1'b1;
            active   <= 1'b0;
            idx      <= '0;
            dcnt     <= '0;
            tgt      <= '0;
            sh       <= '0;
            rx_data  <= '0;
            rx_avail <= 1'b0;
        end else begin
            s1 <= rxd;
            s2 <= s1;
            if (!cfg.en) begin
                active <= 1'b0;
            end else if (!active) begin
                if (!s2) begin
                    active <= 1'b1;
                    idx    <= '0;
                    dcnt   <= '0;
                    tgt    <= div_last(cfg.clk_rate) >> 1;
                end
            end else if (tick) begin
                if (hit) begin
                    dcnt <= '0;
                    tgt  <= div_last(cfg.clk_rate);
                    idx  <= idx + 4'd1;
                    if (idx == 4'd0) begin
                        if (s2) active <= 1'b0;
                    end else if (idx <= n) begin
                        sh <= {s2, sh[DATA_W-1:1]};
                    end else if (idx == last) begin
                        active  <= 1'b0;
                        rx_data <= sh >> (4'(DATA_W) - n);
                    end
                end else begin
                    dcnt <= dcnt + DIV_W'(1);
                end
            end

            if (done)        rx_avail <= 1'b1;
            else if (dat_rd) rx_avail <= 1'b0;
        end
    end

    AST_RX_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_avail) |-> $past(cfg.en)); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && !done) |=> !rx_avail); // R10

endmodule

// File: rtl/sch_async_chan.sv
module sch_async_chan
    import sch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       ctl_wr,
    input  logic       dat_wr,
    input  logic       dat_rd,
    input  logic [7:0] wdata,
    output logic [7:0] rx_data,
    output logic       stat_txe,
    output logic       stat_all_sent,
    output logic       stat_rx_avail,
    input  logic       rxd,
    output logic       txd
);
    txcfg_t txc;
    rxcfg_t rxc;

    sch_regs u_regs (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wdata(wdata),
        .txc(txc), .rxc(rxc)
    );

    sch_tx u_tx (
        .clk(clk), .rst(rst), .tick(tick), .cfg(txc),
        .dat_wr(dat_wr), .wdata(wdata),
        .txd(txd), .txe(stat_txe), .all_sent(stat_all_sent)
    );

    sch_rx u_rx (
        .clk(clk), .rst(rst), .tick(tick), .cfg(rxc),
        .rxd(rxd), .dat_rd(dat_rd),
        .rx_data(rx_data), .rx_avail(stat_rx_avail)
    );

endmodule

// File: tb/sim_sch_async_chan.sv
`timescale 1ns/1ps
module sim_sch_async_chan;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       ctl_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rx_data;
    logic       stat_txe, stat_all_sent, stat_rx_avail;
    logic       rxd = 1'b1;
    logic       txd;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic [7:0] exp_q[$];
    bit mon_en = 1'b1;
    int mon_div = 16;
    int mon_n = 8;
    bit mon_par = 1'b0;
    bit mon_even = 1'b0;

    always #5 clk = ~clk;

    sch_async_chan u0 (
        .clk(clk), .rst(rst), .tick(tick), .ctl_wr(ctl_wr), .dat_wr(dat_wr),
        .dat_rd(dat_rd), .wdata(wdata), .rx_data(rx_data), .stat_txe(stat_txe),
        .stat_all_sent(stat_all_sent), .stat_rx_avail(stat_rx_avail),
        .rxd(rxd), .txd(txd)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic ctl(input logic [7:0] b);
        @(negedge clk); ctl_wr = 1'b1; wdata = b;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] r, input logic [7:0] v);
        ctl(r); ctl(v);
    endtask

    task automatic put(input logic [7:0] b, input bit push);
        if (push) exp_q.push_back(b);
        @(negedge clk); dat_wr = 1'b1; wdata = b;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (mon_div * 3) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input int div);
        @(negedge clk); rxd = 1'b0;
        repeat (div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (div) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (div) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // scoreboard monitor: decodes txd frames and compares with queued bytes
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && !rst && txd === 1'b0) begin
                logic [7:0] got;
                logic [7:0] want;
                logic       pbit, pexp, stopb;
                got = 8'h00;
                repeat (mon_div / 2) @(negedge clk);
                for (int i = 0; i < mon_n; i++) begin
                    repeat (mon_div) @(negedge clk);
                    got[i] = txd;
                end
                pbit = 1'b0;
                if (mon_par) begin
                    repeat (mon_div) @(negedge clk);
                    pbit = txd;
                end
                repeat (mon_div) @(negedge clk);
                stopb = txd;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected frame", got, 0);
                end else begin
                    want = exp_q.pop_front() & 8'((1 << mon_n) - 1);
                    pexp = (^want) ^ ~mon_even;
                    chk(got == want && stopb == 1'b1 && (!mon_par || pbit == pexp),
                        "R4/R3 frame data/parity/stop", {got, 7'b0, pbit},
                        {want, 7'b0, pexp});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_sim();
    end

    initial begin
        int lo, hi;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(txd == 1'b1, "R11 reset txd", txd, 1);
        chk(stat_txe == 1'b1, "R11 reset txe", stat_txe, 1);
        chk(stat_all_sent == 1'b1, "R11 reset all_sent", stat_all_sent, 1);
        chk(stat_rx_avail == 1'b0, "R11 reset rx_avail", stat_rx_avail, 0);

        wreg(8'h04, 8'h44); // R3 x16, 1 stop, no parity

        // R5: transmitter disabled, data written, line stays mark
        put(8'h55, 1'b0);
        lo = 1;
        repeat (100) begin @(negedge clk); if (txd == 1'b0) lo = 0; end
        chk(lo == 1, "R5 disabled txd stays mark", lo, 1);
        chk(stat_txe == 1'b0, "R7 byte held while disabled", stat_txe, 0);

        // R4/R7: enabling moves the byte into the shifter
        exp_q.push_back(8'h55);
        wreg(8'h05, 8'h68);
        repeat (3) @(negedge clk);
        chk(stat_txe == 1'b1, "R7 load sets txe", stat_txe, 1);
        chk(stat_all_sent == 1'b0, "R8 not all sent while shifting", stat_all_sent, 0);
        drain();
        chk(stat_all_sent == 1'b1, "R8 all sent after char", stat_all_sent, 1);

        // R11: data write clears flags on next clock
        put(8'hA5, 1'b1);
        chk(stat_txe == 1'b0, "R11 write clears txe", stat_txe, 0);
        chk(stat_all_sent == 1'b0, "R11 write clears all_sent", stat_all_sent, 0);
        repeat (4) @(negedge clk);
        put(8'h3C, 1'b1);
        repeat (10) @(negedge clk);
        chk(stat_txe == 1'b0, "R7 second byte waits for char end", stat_txe, 0);
        drain();
        chk(stat_txe == 1'b1 && stat_all_sent == 1'b1, "R8 both bytes sent",
            {stat_txe, stat_all_sent}, 3);

        // R1: after a register write the pointer is zero; 0x10 is a command
        ctl(8'h10);
        put(8'h81, 1'b1);
        drain();
        chk(exp_q.size() == 0 && stat_all_sent == 1'b1, "R1 pointer returned to zero",
            stat_all_sent, 1);

        // R3: 7-bit, even then odd parity
        wreg(8'h04, 8'h47);
        wreg(8'h05, 8'h48);
        mon_n = 7; mon_par = 1'b1; mon_even = 1'b1;
        put(8'h5B, 1'b1);
        drain();
        wreg(8'h04, 8'h45);
        mon_even = 1'b0;
        put(8'h2E, 1'b1);
        drain();

        // R3: x32 bit time, 8 bits
        wreg(8'h04, 8'h84);
        wreg(8'h05, 8'h68);
        mon_div = 32; mon_n = 8; mon_par = 1'b0;
        put(8'hC3, 1'b1);
        drain();
        wreg(8'h04, 8'h44);
        mon_div = 16;

        // R6: break holds line low, no load
        mon_en = 1'b0;
        wreg(8'h05, 8'h78);
        repeat (3) @(negedge clk);
        hi = 0;
        put(8'h99, 1'b0);
        repeat (60) begin @(negedge clk); if (txd == 1'b1) hi = 1; end
        chk(hi == 0, "R6 break holds txd low", hi, 0);
        chk(stat_txe == 1'b0, "R6 no load during break", stat_txe, 0);
        wreg(8'h05, 8'h00);
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R5 disabled over break gives mark", txd, 1);
        exp_q.push_back(8'h99);
        mon_en = 1'b1;
        wreg(8'h05, 8'h68);
        drain();
        chk(exp_q.size() == 0, "R7 held byte sent after break", exp_q.size(), 0);

        // R2/R10: receive
        wreg(8'h03, 8'hC1);
        send_rx(8'h96, 16);
        chk(stat_rx_avail == 1'b1, "R10 rx_avail set", stat_rx_avail, 1);
        chk(rx_data == 8'h96, "R2 R10 rx data", rx_data, 8'h96);
        @(negedge clk); dat_rd = 1'b1; @(negedge clk); dat_rd = 1'b0;
        chk(stat_rx_avail == 1'b0, "R10 read clears rx_avail", stat_rx_avail, 0);
        send_rx(8'h3A, 16);
        chk(rx_data == 8'h3A && stat_rx_avail == 1'b1, "R10 second rx byte", rx_data, 8'h3A);
        @(negedge clk); dat_rd = 1'b1; @(negedge clk); dat_rd = 1'b0;

        // R9: receiver disabled ignores line
        wreg(8'h03, 8'hC0);
        send_rx(8'h11, 16);
        chk(stat_rx_avail == 1'b0, "R9 disabled no rx_avail", stat_rx_avail, 0);
        chk(rx_data == 8'h3A, "R9 disabled keeps rx data", rx_data, 8'h3A);

        finish_sim();
    end
endmodule